// File: doc/BRIEF.md
# TDM Transmit Time-Slot Mapper

The block takes payload bytes through a ready/valid handshake and sends them bit-serially onto one time-division-multiplexed output link. A frame is either 193 bits long (one framing bit followed by 24 eight-bit slots) or 256 bits long (32 eight-bit slots). A 32-bit slot mask picks which slots carry payload. Every other bit time, including the framing bit of the 193-bit format, deasserts the output enable so that the pad can float. Any subset of slots may be enabled, from a single 64 kb/s channel up to all 32.

The block runs on a fast system clock. It samples the slower link clock and advances one bit on the selected edge of that clock. The frame pulse is either produced by the block or taken from an external source, with a selectable active level. Bytes are sent MSB first. A byte is requested only in the bit time that opens an enabled slot. When none is offered, an idle byte is sent and an underrun pulse is raised. Framing and mask settings are picked up only at a frame start.

Top module: `tdm_tx_mapper`

## Requirements
- R1: In generate mode (`fp_src_i`=1) a frame lasts 193 bit times when `mode_i`=0 and 256 when `mode_i`=1. `fp_o` is at its active level for exactly the first bit of each frame and at the opposite level for every other bit.
- R2: The slot mask is {`mask_hi_i`,`mask_lo_i`}, and bit k controls slot k. A 1 drives `oe_o` high for all 8 bits of the slot, which carry payload. A 0 holds `oe_o` low for the whole slot.
- R3: With `mode_i`=0, the first bit of the frame is a framing bit with `oe_o` low. Bits 1 to 192 form slots 0 to 23 in order.
- R4: With `mode_i`=0, mask bits 31 to 24 have no effect on the output.
- R5: With `mode_i`=1, frame bit 0 is bit 0 of slot 0, and all 32 mask bits apply.
- R6: Each payload byte is sent MSB first on `sdo_o`. `in_ready_o` is high for exactly one clock cycle, in the bit time that opens an enabled slot, and a byte moves only when `in_valid_i` and `in_ready_o` are both high.
- R7: If `in_valid_i` is low when an enabled slot opens, the slot carries 0xFF and `underrun_o` is high for one clock cycle.
- R8: In accept mode (`fp_src_i`=0), a bit time in which `fp_i` is at its active level becomes frame bit 0. Without a pulse the frame counter wraps on its own. In generate mode `fp_i` is ignored.
- R9: `fp_pol_i`=1 makes the frame pulse active high on both `fp_i` and `fp_o`. `fp_pol_i`=0 makes it active low on both.
- R10: `edge_sel_i`=1 advances one bit on each rising edge of `lclk_i`, and `edge_sel_i`=0 on each falling edge. `oe_o`, `sdo_o` and `fp_o` change only right after such an edge.
- R11: A change of `mode_i` or of the mask takes effect at the next frame start. The frame already under way keeps its old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lclk_i | input | 1 | Link bit clock |
| edge_sel_i | input | 1 | 1: rising link-clock edge, 0: falling |
| fp_src_i | input | 1 | 1: generate frame pulse, 0: accept `fp_i` |
| fp_pol_i | input | 1 | 1: frame pulse active high, 0: active low |
| fp_i | input | 1 | External frame pulse |
| fp_o | output | 1 | Frame pulse, generated from the block's own frame position |
| mode_i | input | 1 | 0: 193-bit framing, 1: 256-bit framing |
| mask_lo_i | input | 16 | Enable bits for slots 0 to 15 |
| mask_hi_i | input | 16 | Enable bits for slots 16 to 31 |
| in_data_i | input | 8 | Payload byte |
| in_valid_i | input | 1 | Payload byte available |
| in_ready_o | output | 1 | Byte taken in this cycle |
| sdo_o | output | 1 | Serial data |
| oe_o | output | 1 | Output enable; low means high impedance |
| underrun_o | output | 1 | Pulse: an enabled slot opened without a byte |

## Verification
The bench builds the block with its default parameters: 8-bit slots, 32 slots per long frame, 24 per short frame and two synchronizer stages. With these values both frame lengths, their wrap points and the switch between them fit within a few thousand link bits. The mask can be exercised at both extremes: one slot, and all 32. With two synchronizer stages, the delay from a link-clock edge to the outputs is a fixed three system cycles. The bench can therefore drive the frame pulse together with the link clock and sample the outputs late in every bit time, for either edge and either pulse polarity.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  typedef enum logic {
    FRM_193 = 1'b0,
    FRM_256 = 1'b1
  } frame_mode_e;
endpackage

// File: rtl/tdm_link_sync.sv
module tdm_link_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lclk_i,
  input  logic fp_i,
  input  logic edge_sel_i,
  input  logic fp_pol_i,
  output logic tick_o,
  output logic fp_act_o
);
  logic [SYNC_STAGES:0]   lclk_pipe;
  logic [SYNC_STAGES-1:0] fp_pipe;

  for (genvar s = 0; s <= SYNC_STAGES; s++) begin : g_lclk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lclk_pipe[s] <= 1'b0;
      else if (s == 0) lclk_pipe[s] <= lclk_i;
      else lclk_pipe[s] <= lclk_pipe[(s == 0) ? 0 : s-1];
    end
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_fp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fp_pipe[s] <= 1'b0;
      else if (s == 0) fp_pipe[s] <= fp_i;
      else fp_pipe[s] <= fp_pipe[(s == 0) ? 0 : s-1];
    end
  end

  // fp is aligned with the lclk sample that produces the tick
  always_comb begin
    if (edge_sel_i) tick_o = lclk_pipe[SYNC_STAGES-1] & ~lclk_pipe[SYNC_STAGES];
    else            tick_o = ~lclk_pipe[SYNC_STAGES-1] & lclk_pipe[SYNC_STAGES];
    fp_act_o = (fp_pipe[SYNC_STAGES-1] == fp_pol_i);
  end
endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
  import tdm_tx_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int N_SLOTS   = 32,
  parameter int T1_SLOTS  = 24,
  localparam int POS_W    = $clog2(N_SLOTS*SLOT_BITS),
  localparam int BIT_W    = $clog2(SLOT_BITS),
  localparam int SLOT_W   = $clog2(N_SLOTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               fp_act_i,
  input  logic               fp_src_i,
  input  logic               fp_pol_i,
  input  logic               mode_i,
  input  logic [N_SLOTS-1:0] mask_i,
  output logic               slot_on_o,
  output logic               slot_first_o,
  output logic               fp_o,
  output logic [POS_W-1:0]   pos_o,
  output frame_mode_e        mode_o,
  output logic [N_SLOTS-1:0] mask_o
);
  localparam logic [POS_W-1:0] LEN256_M1 = POS_W'(N_SLOTS*SLOT_BITS - 1);
  localparam logic [POS_W-1:0] LEN193_M1 = POS_W'(T1_SLOTS*SLOT_BITS);

  logic [POS_W-1:0]   pos_q, nxt_pos, len_m1, q_pos;
  frame_mode_e        mode_q, nxt_mode;
  logic [N_SLOTS-1:0] mask_q, nxt_mask;
  logic               fp_q, frame_start, nxt_fbit;
  logic [SLOT_W-1:0]  nxt_slot;
  logic [BIT_W-1:0]   nxt_bit;

  always_comb begin
    len_m1      = (mode_q == FRM_193) ? LEN193_M1 : LEN256_M1;
    if (!fp_src_i && fp_act_i) nxt_pos = '0;
    else if (pos_q == len_m1)  nxt_pos = '0;
    else                       nxt_pos = pos_q + 1'b1;
    frame_start = (nxt_pos == '0);
    nxt_mode    = frame_start ? frame_mode_e'(mode_i) : mode_q;
    nxt_mask    = frame_start ? mask_i : mask_q;
    nxt_fbit    = (nxt_mode == FRM_193) && frame_start;
    q_pos       = (nxt_mode == FRM_193) ? nxt_pos - 1'b1 : nxt_pos;
    nxt_slot    = SLOT_W'(q_pos >> BIT_W);
    nxt_bit     = q_pos[BIT_W-1:0];
    slot_on_o   = !nxt_fbit && nxt_mask[nxt_slot];
    slot_first_o = (nxt_bit == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= LEN256_M1;
      mode_q <= FRM_256;
      mask_q <= '0;
      fp_q   <= 1'b0;
    end else if (tick_i) begin
      pos_q  <= nxt_pos;
      mode_q <= nxt_mode;
      mask_q <= nxt_mask;
      fp_q   <= frame_start ? fp_pol_i : ~fp_pol_i;
    end
  end

  assign fp_o   = fp_q;
  assign pos_o  = pos_q;
  assign mode_o = mode_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/tdm_slot_serializer.sv
module tdm_slot_serializer #(
  parameter int             SLOT_BITS = 8,
  parameter logic [SLOT_BITS-1:0] IDLE_BYTE = '1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 slot_on_i,
  input  logic                 slot_first_i,
  input  logic [SLOT_BITS-1:0] in_data_i,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  output logic                 sdo_o,
  output logic                 oe_o,
  output logic                 underrun_o
);
  logic [SLOT_BITS-1:0] shreg_q;
  logic                 oe_q, urun_q, load;

  assign load       = tick_i && slot_on_i && slot_first_i;
  assign in_ready_o = load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      oe_q    <= 1'b0;
      urun_q  <= 1'b0;
    end else begin
      urun_q <= load && !in_valid_i;
      if (tick_i) begin
        oe_q <= slot_on_i;
        if (load) shreg_q <= in_valid_i ? in_data_i : IDLE_BYTE;
        else      shreg_q <= {shreg_q[SLOT_BITS-2:0], 1'b0};
      end
    end
  end

  assign sdo_o      = shreg_q[SLOT_BITS-1];
  assign oe_o       = oe_q;
  assign underrun_o = urun_q;
endmodule

// File: rtl/tdm_tx_mapper.sv
module tdm_tx_mapper
  import tdm_tx_pkg::*;
#(
  parameter int SLOT_BITS   = 8,
  parameter int N_SLOTS     = 32,
  parameter int T1_SLOTS    = 24,
  parameter int SYNC_STAGES = 2,
  localparam int HALF_W     = N_SLOTS/2,
  localparam int POS_W      = $clog2(N_SLOTS*SLOT_BITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 lclk_i,
  input  logic                 edge_sel_i,
  input  logic                 fp_src_i,
  input  logic                 fp_pol_i,
  input  logic                 fp_i,
  output logic                 fp_o,
  input  logic                 mode_i,
  input  logic [HALF_W-1:0]    mask_lo_i,
  input  logic [HALF_W-1:0]    mask_hi_i,
  input  logic [SLOT_BITS-1:0] in_data_i,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  output logic                 sdo_o,
  output logic                 oe_o,
  output logic                 underrun_o
);
  logic               tick, fp_act, slot_on, slot_first;
  logic [POS_W-1:0]   pos_q;
  frame_mode_e        mode_q;
  logic [N_SLOTS-1:0] mask_q;

  tdm_link_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .lclk_i, .fp_i, .edge_sel_i, .fp_pol_i,
    .tick_o(tick), .fp_act_o(fp_act)
  );

  tdm_frame_timer #(.SLOT_BITS(SLOT_BITS), .N_SLOTS(N_SLOTS), .T1_SLOTS(T1_SLOTS)) u_timer (
    .clk_i, .rst_ni, .tick_i(tick), .fp_act_i(fp_act), .fp_src_i, .fp_pol_i,
    .mode_i, .mask_i({mask_hi_i, mask_lo_i}),
    .slot_on_o(slot_on), .slot_first_o(slot_first), .fp_o,
    .pos_o(pos_q), .mode_o(mode_q), .mask_o(mask_q)
  );

  tdm_slot_serializer #(.SLOT_BITS(SLOT_BITS)) u_ser (
    .clk_i, .rst_ni, .tick_i(tick), .slot_on_i(slot_on), .slot_first_i(slot_first),
    .in_data_i, .in_valid_i, .in_ready_o, .sdo_o, .oe_o, .underrun_o
  );
endmodule

// File: rtl/tdm_tx_mapper_chk.sv
module tdm_tx_mapper_chk
  import tdm_tx_pkg::*;
#(
  parameter int N_SLOTS = 32,
  parameter int POS_W   = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick,
  input logic               in_ready_o,
  input logic               oe_o,
  input logic               sdo_o,
  input logic               underrun_o,
  input logic [POS_W-1:0]   pos_q,
  input frame_mode_e        mode_q,
  input logic [N_SLOTS-1:0] mask_q
);
  // R6: a taken byte is followed by a driven slot
  a_r6_ready_then_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |=> oe_o);
  // R6: requests only at a link bit edge
  a_r6_ready_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> tick);
  // R3: framing bit floats
  a_r3_fbit_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == FRM_193 && pos_q == '0) |-> !oe_o);
  // R7: underrun sends idle ones on a driven slot
  a_r7_underrun_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> (oe_o && sdo_o));
  // R10: output enable moves only after a bit edge
  a_r10_oe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick) |-> $stable(oe_o));
  // R11: settings move only at frame start
  a_r11_cfg_at_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q != '0) |-> ($stable(mask_q) && $stable(mode_q)));
endmodule

bind tdm_tx_mapper tdm_tx_mapper_chk #(.N_SLOTS(N_SLOTS), .POS_W(POS_W)) u_chk (
  .clk_i, .rst_ni, .tick, .in_ready_o, .oe_o, .sdo_o, .underrun_o,
  .pos_q, .mode_q, .mask_q
);

// File: tb/tdm_tx_mapper_test.sv
module tdm_tx_mapper_test;
  logic clk = 0, rst_n = 0;
  logic lclk = 0, edge_sel = 1, fp_src = 1, fp_pol = 1, fp_in = 0, mode = 1;
  logic [15:0] mask_lo = '0, mask_hi = '0;
  logic [7:0] in_data;
  logic in_valid = 0;
  logic fp_o, in_ready_o, sdo_o, oe_o, underrun_o;

  int checks = 0, errors = 0;
  int feed_idx = 0, urun_cnt = 0;
  int m_p = 255, m_feed = 0, m_urun = 0;
  bit m_mode = 1;
  logic [31:0] m_mask = '0;
  logic [7:0]  m_byte = '0;

  always #2 clk = ~clk;

  function automatic logic [7:0] pay(int n);
    return 8'(n * 37 + 5);
  endfunction

  assign in_data = pay(feed_idx);

  always @(posedge clk) begin
    if (rst_n && in_valid && in_ready_o) feed_idx <= feed_idx + 1;
    if (rst_n && underrun_o) urun_cnt <= urun_cnt + 1;
  end

  tdm_tx_mapper uut (
    .clk_i(clk), .rst_ni(rst_n), .lclk_i(lclk), .edge_sel_i(edge_sel),
    .fp_src_i(fp_src), .fp_pol_i(fp_pol), .fp_i(fp_in), .fp_o(fp_o),
    .mode_i(mode), .mask_lo_i(mask_lo), .mask_hi_i(mask_hi),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready_o),
    .sdo_o(sdo_o), .oe_o(oe_o), .underrun_o(underrun_o)
  );

  task automatic check(string tag, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one link bit: drive active edge, update reference, sample late in the bit
  task automatic bit_step(string tag, bit pulse);
    int len_m1, np, q, b;
    bit fbit, on, e_fp;
    string t;
    lclk  = edge_sel ? 1'b1 : 1'b0;
    fp_in = pulse ? fp_pol : ~fp_pol;
    len_m1 = m_mode ? 255 : 192;
    if (!fp_src && pulse) np = 0;
    else np = (m_p == len_m1) ? 0 : m_p + 1;
    if (np == 0) begin
      m_mode = mode;
      m_mask = {mask_hi, mask_lo};
    end
    m_p  = np;
    fbit = !m_mode && np == 0;
    q    = m_mode ? np : np - 1;
    b    = fbit ? 0 : q % 8;
    on   = fbit ? 1'b0 : m_mask[q / 8];
    if (on && b == 0) begin
      if (in_valid) begin
        m_byte = pay(m_feed);
        m_feed++;
      end else begin
        m_byte = 8'hFF;
        m_urun++;
      end
    end
    e_fp = (np == 0) ? fp_pol : ~fp_pol;
    repeat (4) @(negedge clk);
    lclk = ~lclk;
    repeat (4) @(negedge clk);
    t = fbit ? "R3" : tag;
    if (on)
      check(t, {fp_o, oe_o, sdo_o} == {e_fp, 1'b1, m_byte[7-b]},
            {fp_o, oe_o, sdo_o}, {e_fp, 1'b1, m_byte[7-b]});
    else
      check(t, {fp_o, oe_o} == {e_fp, 1'b0}, {fp_o, oe_o}, {e_fp, 1'b0});
  endtask

  task automatic run_bits(string tag, int n);
    for (int i = 0; i < n; i++) bit_step(tag, 1'b0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1", {oe_o, in_ready_o, underrun_o, fp_o} == 4'b0,
          {oe_o, in_ready_o, underrun_o, fp_o}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R10", {oe_o, in_ready_o, fp_o} == 3'b0, {oe_o, in_ready_o, fp_o}, 0);
  endtask

  task automatic t_long_frames;
    mode = 1; {mask_hi, mask_lo} = 32'hA5C3_0F01; in_valid = 1;
    run_bits("R5", 512);
    check("R6", feed_idx == m_feed, feed_idx, m_feed);
  endtask

  task automatic t_short_frames;
    mode = 0; {mask_hi, mask_lo} = 32'hFF80_0003;
    run_bits("R4", 193 * 2);
    check("R6", feed_idx == m_feed, feed_idx, m_feed);
  endtask

  task automatic t_cfg_midframe;
    {mask_hi, mask_lo} = 32'h0000_FFFF;
    run_bits("R11", 100);
    {mask_hi, mask_lo} = 32'hFFFF_0000; mode = 1;
    run_bits("R11", 93 + 256);
  endtask

  task automatic t_mask_extremes;
    {mask_hi, mask_lo} = 32'h0000_0001;
    run_bits("R2", 256);
    {mask_hi, mask_lo} = 32'hFFFF_FFFF;
    run_bits("R2", 256);
    check("R6", feed_idx == m_feed, feed_idx, m_feed);
  endtask

  task automatic t_underrun;
    int u0, f0;
    u0 = urun_cnt; f0 = feed_idx;
    in_valid = 0;
    run_bits("R7", 256);
    check("R7", urun_cnt - u0 == 32, urun_cnt - u0, 32);
    check("R7", feed_idx == f0, feed_idx, f0);
    in_valid = 1;
  endtask

  task automatic t_gen_ignores_fp;
    for (int i = 0; i < 256; i++) bit_step("R8", i == 77);
  endtask

  task automatic t_accept;
    {mask_hi, mask_lo} = 32'h0000_0F0F;
    edge_sel = 0; fp_src = 0; fp_pol = 0;
    lclk = 1; fp_in = 1;
    repeat (8) @(negedge clk);
    run_bits("R10", 40);
    bit_step("R8", 1'b1);
    for (int i = 1; i < 600; i++) bit_step("R9", (i % 256) == 0 || i == 300);
    check("R6", feed_idx == m_feed, feed_idx, m_feed);
    check("R7", urun_cnt == m_urun, urun_cnt, m_urun);
  endtask

  initial begin
    t_reset();
    t_long_frames();
    t_short_frames();
    t_cfg_midframe();
    t_mask_extremes();
    t_underrun();
    t_gen_ignores_fp();
    t_accept();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule